// File: doc/BRIEF.md
# Row-Buffered EEPROM Write Controller

This block sits between a CPU byte bus and a small on-chip data EEPROM whose storage array is written one row at a time. Writing is a two-step sequence. Software first turns on a latch-enable bit in the control register and writes bytes into a row-wide set of data latches. It then sets a program bit. A timed programming cycle copies only the bytes that were actually written into the chosen row of the array. When the cycle ends, hardware clears both control bits and the array can be read again.

While latching is enabled, data-window reads leave the bus undriven. While it is off, data-window writes are dropped. The block also takes two low-power requests. A wait request is held off until a running programming cycle completes. A halt request aborts any cycle at once, which can leave the target row partly written. The array is modelled as a register file with one write port and one registered read port.

Top module: `eeprom_row_ctrl`

## Requirements
- R1: After reset, including a reset asserted in the middle of a programming cycle, `busy`, `lp_ack` and `cpu_rd_oe` are 0 and the control register reads 0.
- R2: The control register is selected by `cpu_reg`=1. Bit 1 is latch-enable and bit 0 is program. A read returns `{0..0, latch, program}` on `cpu_rdata`, with `cpu_rd_oe`=1, in the cycle after the request.
- R3: A data-window read (`cpu_reg`=0) while latch-enable is 1 gives `cpu_rd_oe`=0 in the following cycle.
- R4: A data-window write while latch-enable is 0 is ignored. No latch is updated and the array is unchanged.
- R5: The row is taken from address bits [ADDR_W-1:5] of the first data write after latch-enable is set. Later writes in that phase use only bits [4:0] to select the byte within that row.
- R6: Writing the control register with bit 0 = 1 while latch-enable is 1 raises `busy` on the next cycle and holds it for exactly PROG_CYCLES cycles. Program and latch-enable clear on the same edge on which `busy` falls.
- R7: A programming cycle updates only the row bytes written during the latch phase, and other bytes of the row keep their old value. All byte flags clear at the end of the cycle, so the next cycle carries over nothing.
- R8: Control-register writes while `busy` is 1 are ignored, including attempts to clear the program bit. Setting bit 0 while latch-enable is 0 leaves the program bit at 0.
- R9: Clearing latch-enable without setting program discards every latched byte, and the next latch phase selects its row afresh.
- R10: With `wait_req`=1 and no cycle running, `lp_ack` is 1 one cycle later. If a cycle is running, `lp_ack` stays 0 until `busy` falls and rises on the following cycle.
- R11: `halt_req`=1 aborts a running cycle. `busy`, latch-enable and program read 0 and `lp_ack` is 1 on the next cycle, and bus writes are ignored while halt is held.
- R12: A data-window read while latch-enable is 0 returns the array byte at `cpu_addr`, with `cpu_rd_oe`=1, in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_sel | input | 1 | Bus access strobe, one cycle per access |
| cpu_we | input | 1 | 1 = write access, 0 = read access |
| cpu_reg | input | 1 | 1 = control register, 0 = data window |
| cpu_addr | input | ADDR_W | Byte address in the data window |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid when cpu_rd_oe is 1 |
| cpu_rd_oe | output | 1 | Read data is driven on the bus |
| wait_req | input | 1 | Request to enter the wait state |
| halt_req | input | 1 | Request to halt, aborts programming |
| busy | output | 1 | Programming cycle in progress |
| lp_ack | output | 1 | Block is in a low-power state |

## Verification
Two pairs of functions can land on the same edge. A wait request held across the completion of a programming cycle is provoked by raising `wait_req` while `busy` is high. It is judged by `lp_ack` staying low through the whole cycle and rising exactly one cycle after `busy` falls. A halt is raised a few cycles into a cycle, while the array is being swept. It is judged by `busy` and both control bits reading 0 on the next cycle, by a control write during the halt having no effect, and by a full rewrite of the damaged row restoring the bench's model.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
  localparam int CTL_PROG_BIT  = 0;
  localparam int CTL_LATCH_BIT = 1;

  typedef struct packed {
    logic lat;
    logic prog;
  } ctl_t;
endpackage

// File: rtl/eeprom_data_array.sv
module eeprom_data_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/eeprom_row_latch.sv
module eeprom_row_latch #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int ROW_BYTES = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     clear,
  input  logic [$clog2(ROW_BYTES)-1:0] rd_idx,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     rd_valid,
  output logic [ADDR_W-$clog2(ROW_BYTES)-1:0] row,
  output logic [ROW_BYTES-1:0]     valid_vec
);
  localparam int OFS_W = $clog2(ROW_BYTES);
  localparam int ROW_W = ADDR_W - OFS_W;

  logic [DATA_W-1:0] lat_mem [ROW_BYTES];
  logic              row_set;
  logic [ROW_W-1:0]  row_q;
  logic [OFS_W-1:0]  ofs;

  assign ofs = wr_addr[OFS_W-1:0];

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      valid_vec <= '0;
      row_set   <= 1'b0;
      row_q     <= '0;
    end else if (wr_en) begin
      valid_vec[ofs] <= 1'b1;
      if (!row_set) begin
        row_q   <= wr_addr[ADDR_W-1:OFS_W];
        row_set <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) lat_mem[ofs] <= wr_data;
  end

  assign rd_data  = lat_mem[rd_idx];
  assign rd_valid = valid_vec[rd_idx];
  assign row      = row_q;

  a_r7_flags_clear: assert property (@(posedge clk) disable iff (rst)
    clear |=> (valid_vec == '0));
  a_r5_row_held: assert property (@(posedge clk) disable iff (rst)
    (row_set && !clear) |=> $stable(row_q));
endmodule

// File: rtl/eeprom_prog_timer.sv
module eeprom_prog_timer #(
  parameter int ROW_BYTES   = 32,
  parameter int PROG_CYCLES = 1000
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start,
  input  logic                         abort,
  output logic                         busy,
  output logic                         sweep,
  output logic [$clog2(ROW_BYTES)-1:0] idx,
  output logic                         done
);
  localparam int OFS_W = $clog2(ROW_BYTES);
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PROG_CYCLES - 1);
  localparam logic [CNT_W-1:0] SWEEP_END = CNT_W'(ROW_BYTES);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == LAST) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign done  = busy && (cnt == LAST) && !abort;
  assign sweep = busy && (cnt < SWEEP_END) && !abort;
  assign idx   = cnt[OFS_W-1:0];

  a_r11_halt_abort: assert property (@(posedge clk) disable iff (rst)
    abort |=> !busy);
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt <= LAST));
  a_r6_idle_count: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (cnt == '0));
endmodule

// File: rtl/eeprom_row_ctrl.sv
module eeprom_row_ctrl
  import eeprom_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int ROW_BYTES   = 32,
  parameter int PROG_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_sel,
  input  logic              cpu_we,
  input  logic              cpu_reg,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_rd_oe,
  input  logic              wait_req,
  input  logic              halt_req,
  output logic              busy,
  output logic              lp_ack
);
  localparam int OFS_W = $clog2(ROW_BYTES);
  localparam int ROW_W = ADDR_W - OFS_W;

  ctl_t              ctl_q;
  logic              wr_ctl, wr_dat, start, discard, done;
  logic              sweep, lat_valid, arr_we;
  logic [OFS_W-1:0]  idx;
  logic [ROW_W-1:0]  row;
  logic [DATA_W-1:0] lat_data, arr_q, ctl_snap;
  logic [ROW_BYTES-1:0] valid_vec;
  logic              rd_oe_q, rd_reg_q, lp_q;

  assign wr_ctl  = cpu_sel && cpu_we && cpu_reg && !halt_req && !busy;
  assign wr_dat  = cpu_sel && cpu_we && !cpu_reg && !halt_req && !busy && ctl_q.lat;
  assign start   = wr_ctl && cpu_wdata[CTL_PROG_BIT] && ctl_q.lat;
  assign discard = wr_ctl && !start && ctl_q.lat && !cpu_wdata[CTL_LATCH_BIT];

  always_ff @(posedge clk) begin
    if (rst || halt_req || done) begin
      ctl_q <= '0;
    end else if (start) begin
      ctl_q.prog <= 1'b1;
    end else if (wr_ctl) begin
      ctl_q.lat <= cpu_wdata[CTL_LATCH_BIT];
    end
  end

  eeprom_prog_timer #(.ROW_BYTES(ROW_BYTES), .PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .start(start), .abort(halt_req),
    .busy(busy), .sweep(sweep), .idx(idx), .done(done)
  );

  eeprom_row_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROW_BYTES(ROW_BYTES)) u_latch (
    .clk(clk), .rst(rst), .wr_en(wr_dat), .wr_addr(cpu_addr), .wr_data(cpu_wdata),
    .clear(halt_req || done || discard), .rd_idx(idx), .rd_data(lat_data),
    .rd_valid(lat_valid), .row(row), .valid_vec(valid_vec)
  );

  assign arr_we = sweep && lat_valid;

  eeprom_data_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .we(arr_we), .waddr({row, idx}), .wdata(lat_data),
    .raddr(cpu_addr), .rdata(arr_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_oe_q  <= 1'b0;
      rd_reg_q <= 1'b0;
      ctl_snap <= '0;
      lp_q     <= 1'b0;
    end else begin
      rd_oe_q  <= cpu_sel && !cpu_we && (cpu_reg || !ctl_q.lat);
      rd_reg_q <= cpu_reg;
      ctl_snap <= {{(DATA_W-2){1'b0}}, ctl_q.lat, ctl_q.prog};
      lp_q     <= halt_req || (wait_req && !busy && !start);
    end
  end

  assign cpu_rd_oe = rd_oe_q;
  assign cpu_rdata = !rd_oe_q ? '0 : (rd_reg_q ? ctl_snap : arr_q);
  assign lp_ack    = lp_q;

  a_r3_read_float: assert property (@(posedge clk) disable iff (rst)
    (cpu_sel && !cpu_we && !cpu_reg && ctl_q.lat) |=> !cpu_rd_oe);
  a_r4_write_drop: assert property (@(posedge clk) disable iff (rst)
    (cpu_sel && cpu_we && !cpu_reg && !ctl_q.lat) |=> $stable(valid_vec));
  a_r6_end_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (!ctl_q.lat && !ctl_q.prog));
  a_r8_prog_needs_latch: assert property (@(posedge clk) disable iff (rst)
    ctl_q.prog |-> ctl_q.lat);
  a_r10_wait_defer: assert property (@(posedge clk) disable iff (rst)
    (busy && wait_req && !halt_req) |=> !lp_ack);
  a_r6_busy_prog: assert property (@(posedge clk) disable iff (rst)
    busy |-> ctl_q.prog);
endmodule

// File: tb/eeprom_row_ctrl_test.sv
module eeprom_row_ctrl_test;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int RB = 32;
  localparam int PC = 120;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_sel = 0, cpu_we = 0, cpu_reg = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic [DW-1:0] cpu_rdata;
  logic cpu_rd_oe, busy, lp_ack;
  logic wait_req = 0, halt_req = 0;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;

  logic [7:0] m_mem [256];
  logic [7:0] m_lat [RB];
  bit         m_val [RB];
  bit         m_en, m_rowset;
  logic [2:0] m_row;

  eeprom_row_ctrl #(.ADDR_W(AW), .DATA_W(DW), .ROW_BYTES(RB), .PROG_CYCLES(PC)) uut (
    .clk(clk), .rst(rst), .cpu_sel(cpu_sel), .cpu_we(cpu_we), .cpu_reg(cpu_reg),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_rd_oe(cpu_rd_oe), .wait_req(wait_req), .halt_req(halt_req),
    .busy(busy), .lp_ack(lp_ack)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [7:0] exp_ctl(input bit lat, input bit prog);
    return {6'b0, lat, prog};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input bit r, input logic [7:0] a, input logic [7:0] d);
    cpu_sel = 1; cpu_we = 1; cpu_reg = r; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_sel = 0; cpu_we = 0;
  endtask

  task automatic bus_rd(input bit r, input logic [7:0] a, output logic oe, output logic [7:0] d);
    cpu_sel = 1; cpu_we = 0; cpu_reg = r; cpu_addr = a;
    @(negedge clk);
    cpu_sel = 0;
    oe = cpu_rd_oe; d = cpu_rdata;
  endtask

  task automatic set_ctl(input logic [7:0] d);
    bus_wr(1, 8'h00, d);
    if (m_en && d[0]) begin
      // program start, handled by m_program
    end else begin
      if (m_en && !d[1]) begin
        for (int i = 0; i < RB; i++) m_val[i] = 0;
        m_rowset = 0;
      end
      m_en = d[1];
    end
  endtask

  task automatic dwrite(input logic [7:0] a, input logic [7:0] d);
    bus_wr(0, a, d);
    if (m_en) begin
      if (!m_rowset) begin m_row = a[7:5]; m_rowset = 1; end
      m_lat[a[4:0]] = d;
      m_val[a[4:0]] = 1;
    end
  endtask

  task automatic m_commit();
    for (int i = 0; i < RB; i++) begin
      if (m_val[i]) m_mem[{m_row, 5'(i)}] = m_lat[i];
      m_val[i] = 0;
    end
    m_rowset = 0;
    m_en = 0;
  endtask

  // start a cycle (latch must be on), count busy cycles, commit the model
  task automatic program_and_wait(input string req);
    int n = 0;
    set_ctl(8'h03);
    while (busy && n < PC + 10) begin n++; @(negedge clk); end
    check(n == PC, req, n, PC);
    m_commit();
  endtask

  task automatic verify_row(input logic [2:0] r, input string req);
    logic oe; logic [7:0] d;
    for (int i = 0; i < RB; i++) begin
      bus_rd(0, {r, 5'(i)}, oe, d);
      check(oe === 1'b1 && d === m_mem[{r, 5'(i)}], req, {oe, d}, {1'b1, m_mem[{r, 5'(i)}]});
    end
  endtask

  task automatic fill_row(input logic [2:0] r);
    set_ctl(8'h02);
    for (int i = 0; i < RB; i++) dwrite({r, 5'(i)}, 8'($urandom));
    program_and_wait("R6 fill length");
  endtask

  initial begin
    logic oe; logic [7:0] d;
    int n;
    void'($urandom(32'd20240611));
    m_en = 0; m_rowset = 0; m_row = 0;
    for (int i = 0; i < RB; i++) begin m_val[i] = 0; m_lat[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    check(busy == 0 && lp_ack == 0 && cpu_rd_oe == 0, "R1 reset outputs", {busy, lp_ack, cpu_rd_oe}, 0);
    bus_rd(1, 0, oe, d);
    check(oe == 1 && d == exp_ctl(0, 0), "R1/R2 reset ctrl read", {oe, d}, {1'b1, exp_ctl(0, 0)});

    for (int r = 0; r < 8; r++) fill_row(3'(r));
    for (int r = 0; r < 8; r++) verify_row(3'(r), "R12 array read after fill");

    // R4 write with latch off is ignored
    dwrite(8'h25, 8'hA5);
    set_ctl(8'h02);
    dwrite(8'h40, 8'h11);
    program_and_wait("R6 length");
    verify_row(3'd1, "R4 dropped write left array");
    verify_row(3'd2, "R7 single byte row");

    // R3 read floats while latch on, R2 control read
    set_ctl(8'h02);
    bus_rd(0, 8'h10, oe, d);
    check(oe == 0, "R3 read floats", oe, 0);
    bus_rd(1, 0, oe, d);
    check(oe == 1 && d == exp_ctl(1, 0), "R2 ctrl latch on", d, exp_ctl(1, 0));

    // R9 discard: latch into row 3, then clear latch-enable
    dwrite(8'h63, 8'hEE);
    set_ctl(8'h00);
    set_ctl(8'h02);
    dwrite(8'hA7, 8'h5A);        // row 5 now chosen afresh
    program_and_wait("R6 length");
    verify_row(3'd3, "R9 discarded bytes");
    verify_row(3'd5, "R9 new row");

    // R8 program bit with latch off is ignored
    set_ctl(8'h01);
    bus_rd(1, 0, oe, d);
    check(d == exp_ctl(0, 0) && busy == 0, "R8 prog without latch", {busy, d}, 0);

    // R8 control writes ignored while busy; R6 control clear at end
    set_ctl(8'h02);
    dwrite(8'hC0, 8'h77);
    bus_wr(1, 0, 8'h03);
    bus_wr(1, 0, 8'h00);
    bus_rd(1, 0, oe, d);
    check(busy == 1 && d == exp_ctl(1, 1), "R8 clear ignored while busy", {busy, d}, {1'b1, exp_ctl(1, 1)});
    // R10 wait deferred while busy
    wait_req = 1;
    n = 0;
    while (busy && n < PC + 10) begin
      check(lp_ack == 0, "R10 lp_ack held during cycle", lp_ack, 0);
      n++; @(negedge clk);
    end
    check(lp_ack == 0, "R10 lp_ack not with busy fall", lp_ack, 0);
    bus_rd(1, 0, oe, d);
    check(d == exp_ctl(0, 0), "R6 ctrl cleared at end", d, exp_ctl(0, 0));
    check(lp_ack == 1, "R10 lp_ack after cycle", lp_ack, 1);
    m_en = 1; m_commit();
    wait_req = 0;
    @(negedge clk);
    check(lp_ack == 0, "R10 lp_ack release", lp_ack, 0);
    wait_req = 1;
    @(negedge clk);
    check(lp_ack == 1, "R10 idle wait immediate", lp_ack, 1);
    wait_req = 0;
    @(negedge clk);
    verify_row(3'd6, "R7 partial row");

    // R11 halt during sweep
    set_ctl(8'h02);
    for (int i = 0; i < RB; i++) dwrite({3'd4, 5'(i)}, 8'(i * 3));
    bus_wr(1, 0, 8'h03);
    repeat (5) @(negedge clk);
    halt_req = 1;
    @(negedge clk);
    check(busy == 0 && lp_ack == 1, "R11 halt abort", {busy, lp_ack}, 2'b01);
    bus_wr(1, 0, 8'h02);
    bus_rd(1, 0, oe, d);
    check(d == exp_ctl(0, 0), "R11 ctrl write during halt ignored", d, exp_ctl(0, 0));
    halt_req = 0;
    @(negedge clk);
    check(lp_ack == 0, "R11 lp_ack after halt", lp_ack, 0);
    m_en = 0; m_rowset = 0;
    for (int i = 0; i < RB; i++) m_val[i] = 0;
    fill_row(3'd4);
    verify_row(3'd4, "R11 row restored");

    // R1 reset mid-cycle
    set_ctl(8'h02);
    dwrite(8'h01, 8'h99);
    bus_wr(1, 0, 8'h03);
    repeat (10) @(negedge clk);
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    @(negedge clk);
    bus_rd(1, 0, oe, d);
    check(busy == 0 && d == exp_ctl(0, 0), "R1 reset mid-cycle", {busy, d}, 0);
    m_en = 0; m_rowset = 0;
    for (int i = 0; i < RB; i++) m_val[i] = 0;
    fill_row(3'd0);

    // random latch phases: R5 row fixed by first write, R7 partial update
    for (int it = 0; it < 16; it++) begin
      logic [2:0] r;
      int cnt;
      r = 3'($urandom);
      cnt = 1 + int'($urandom % 12);
      set_ctl(8'h02);
      dwrite({r, 5'($urandom)}, 8'($urandom));
      for (int k = 1; k < cnt; k++) dwrite(8'($urandom), 8'($urandom));
      program_and_wait("R6 random length");
      verify_row(r, "R5 R7 random row");
    end
    for (int r = 0; r < 8; r++) verify_row(3'(r), "R12 final sweep");

    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule